// File: doc/BRIEF.md
# NAND Sector Hardware ECC Generator

This block sits beside the data port of a NAND flash controller and computes a Hamming-style single-error-correcting code over the bytes that pass through that port. Every 256-byte chunk gets three code bytes: two bytes of line parity that fold in the byte index, and one byte of column parity that folds in the bit position. Two chunks are kept, so a 512-byte sector yields six code bytes. Error correction is left to software.

Software steers the block through a 2-bit mode field: clear, accumulate, drain or off. A calculation starts with clear, then off, then accumulate. After the data has moved, software selects off and then drain. Each data-register read in drain mode then returns the next code byte. The block sees the bus only through a byte-transfer strobe with its data byte, a read strobe for the drain, and the mode field.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, `ecc_o` is 0x00, the byte counter and all accumulators are zero. Draining before any data gives 0xFF for all six bytes.
- R2: The mode field is `mode_i`: 2'b11 clear, 2'b01 accumulate, 2'b10 drain, 2'b00 off. While the field is 2'b11, the byte counter and both chunks' accumulators return to zero, so earlier data leaves no trace.
- R3: In accumulate mode, each cycle with `xfer_i` high folds `xfer_data_i` into the current chunk. Line parity bit 2k+1 toggles when the byte has odd parity and bit k of its index within the chunk is 1. Bit 2k toggles when the byte has odd parity and that index bit is 0 (k = 0..7, 16 bits).
- R4: Column parity is formed from the XOR of all bytes in a chunk. Bit 2j+1 is the parity of the data bit positions whose bit j is 1, and bit 2j is the parity of the positions whose bit j is 0 (j = 0..2). The column code byte carries the inverted column parity in bits 7:2, and bits 1:0 are 1.
- R5: The line-parity bytes are output inverted. A chunk of 256 bytes of 0xFF therefore drains as 0xFF, 0xFF, 0xFF.
- R6: Bytes 0..255 of a session go to chunk 0 and bytes 256..511 go to chunk 1, with the index taken modulo 256.
- R7: Transfers after the 512th byte of a session leave both chunks unchanged.
- R8: Drain order is chunk 0 then chunk 1. Within each chunk the order is the inverted line-parity bits 15:8, then the inverted bits 7:0, then the column code byte.
- R9: Each `rd_i` pulse in drain mode advances the read pointer. After the sixth byte it wraps back to the first.
- R10: Whenever the mode field is not drain, the read pointer returns to the first byte.
- R11: In off mode and in drain mode, `xfer_i` has no effect on the accumulators.
- R12: `ecc_o` is registered. It shows the byte at the read pointer one cycle after drain mode is entered or `rd_i` is sampled, and 0x00 one cycle after any cycle in another mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | ECC mode field from the mode control register |
| xfer_i | input | 1 | One-cycle strobe for a data-port byte transfer |
| xfer_data_i | input | 8 | Byte moved by the transfer |
| rd_i | input | 1 | One-cycle strobe for a data-register read in drain mode |
| ecc_o | output | 8 | Code byte presented for the data-register read |

## Verification
A wrong accumulator bit stays hidden until the drain. It then shows as a wrong code byte on `ecc_o` one cycle after the pointer reaches that byte, so every drained byte is compared against a value computed from the stream the bench sent. A byte counter that is off by one moves data into the wrong chunk or past the 512-byte limit, and this shows as errors across both chunks' bytes in the next drain. Pointer faults show on the very next read, through a wrong order, a missing wrap or a stale position after the mode leaves drain.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W       = 8;
  localparam int CHUNK_ADDR_W = 8;              // 256-byte chunks
  localparam int LP_W         = 2 * CHUNK_ADDR_W;
  localparam int CP_W         = 2 * $clog2(BYTE_W);
  localparam int CODE_BYTES   = 3;

  typedef enum logic [1:0] {
    ECC_OFF   = 2'b00,
    ECC_ACC   = 2'b01,
    ECC_DRAIN = 2'b10,
    ECC_CLEAR = 2'b11
  } ecc_mode_e;

  // R4: column code byte from the running XOR of a chunk's bytes
  function automatic logic [BYTE_W-1:0] col_code(input logic [BYTE_W-1:0] cx);
    logic [CP_W-1:0] cp;
    cp = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      for (int j = 0; j < CP_W/2; j++) begin
        if (((b >> j) & 1) == 1) cp[2*j+1] = cp[2*j+1] ^ cx[b];
        else                     cp[2*j]   = cp[2*j]   ^ cx[b];
      end
    end
    return {~cp, {(BYTE_W-CP_W){1'b1}}};
  endfunction
endpackage

// File: rtl/nand_ecc_chunk_acc.sv
module nand_ecc_chunk_acc
  import nand_ecc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic [CHUNK_ADDR_W-1:0] idx,
  input  logic [BYTE_W-1:0]       data,
  output logic [LP_W-1:0]         lp,
  output logic [BYTE_W-1:0]       colx
);
  logic             odd;
  logic [LP_W-1:0]  lp_delta;

  // R3: a byte of odd parity toggles one bit of each index-bit pair
  always_comb begin
    odd      = ^data;
    lp_delta = '0;
    for (int k = 0; k < CHUNK_ADDR_W; k++) begin
      if (idx[k]) lp_delta[2*k+1] = odd;
      else        lp_delta[2*k]   = odd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp   <= '0;
      colx <= '0;
    end else if (en) begin
      lp   <= lp ^ lp_delta;
      colx <= colx ^ data;
    end
  end
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int TOTAL = NUM_CHUNKS << CHUNK_ADDR_W,
  localparam int CNT_W = $clog2(TOTAL + 1),
  localparam int SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
)(
  input  logic                    clk,
  input  logic                    rst,
  input  ecc_mode_e               mode,
  input  logic                    xfer,
  output logic [CNT_W-1:0]        cnt,
  output logic                    clr,
  output logic [NUM_CHUNKS-1:0]   en,
  output logic [CHUNK_ADDR_W-1:0] idx
);
  logic             take;
  logic [SEL_W-1:0] sel;

  // R7, R11: only accumulate mode with room left takes a byte
  assign take = (mode == ECC_ACC) && xfer && (cnt < CNT_W'(TOTAL));
  assign clr  = (mode == ECC_CLEAR);
  assign idx  = cnt[CHUNK_ADDR_W-1:0];

  if (NUM_CHUNKS > 1) begin : g_sel
    assign sel = cnt[CHUNK_ADDR_W +: SEL_W];
  end else begin : g_nosel
    assign sel = '0;
  end

  // R6: chunk picked by the counter bits above the in-chunk index
  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_en
    assign en[g] = take && (sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;       // R2
    else if (take)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int NUM_OUT = CODE_BYTES * NUM_CHUNKS,
  localparam int PTR_W   = $clog2(NUM_OUT)
)(
  input  logic                                clk,
  input  logic                                rst,
  input  ecc_mode_e                           mode,
  input  logic                                rd,
  input  logic [NUM_CHUNKS-1:0][LP_W-1:0]     lp_all,
  input  logic [NUM_CHUNKS-1:0][BYTE_W-1:0]   colx_all,
  output logic [PTR_W-1:0]                    ptr,
  output logic [BYTE_W-1:0]                   ecc_o
);
  logic [PTR_W-1:0]  ptr_nxt;
  logic [BYTE_W-1:0] code [NUM_OUT];
  logic              drain;

  assign drain = (mode == ECC_DRAIN);

  // R9, R10: advance on read with wrap, home outside drain
  always_comb begin
    if (!drain)                           ptr_nxt = '0;
    else if (rd && ptr == PTR_W'(NUM_OUT-1)) ptr_nxt = '0;
    else if (rd)                          ptr_nxt = ptr + 1'b1;
    else                                  ptr_nxt = ptr;
  end

  // R5, R8: per chunk high line byte, low line byte, column byte
  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_code
    assign code[CODE_BYTES*c]   = ~lp_all[c][LP_W-1 -: BYTE_W];
    assign code[CODE_BYTES*c+1] = ~lp_all[c][BYTE_W-1:0];
    assign code[CODE_BYTES*c+2] = col_code(colx_all[c]);
  end

  // R12: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      ecc_o <= '0;
    end else begin
      ptr   <= ptr_nxt;
      ecc_o <= drain ? code[ptr_nxt] : '0;
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_i,
  input  logic        xfer_i,
  input  logic [7:0]  xfer_data_i,
  input  logic        rd_i,
  output logic [7:0]  ecc_o
);
  localparam int TOTAL   = NUM_CHUNKS << CHUNK_ADDR_W;
  localparam int CNT_W   = $clog2(TOTAL + 1);
  localparam int NUM_OUT = CODE_BYTES * NUM_CHUNKS;
  localparam int PTR_W   = $clog2(NUM_OUT);

  ecc_mode_e                         mode;
  logic [CNT_W-1:0]                  byte_cnt;
  logic                              acc_clr;
  logic [NUM_CHUNKS-1:0]             acc_en;
  logic [CHUNK_ADDR_W-1:0]           byte_idx;
  logic [NUM_CHUNKS-1:0][LP_W-1:0]   lp_all;
  logic [NUM_CHUNKS-1:0][BYTE_W-1:0] colx_all;
  logic [PTR_W-1:0]                  rd_ptr;

  assign mode = ecc_mode_e'(mode_i);

  nand_ecc_seq #(.NUM_CHUNKS(NUM_CHUNKS)) seq_i (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .xfer (xfer_i),
    .cnt  (byte_cnt),
    .clr  (acc_clr),
    .en   (acc_en),
    .idx  (byte_idx)
  );

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    nand_ecc_chunk_acc acc_i (
      .clk  (clk),
      .rst  (rst),
      .clr  (acc_clr),
      .en   (acc_en[g]),
      .idx  (byte_idx),
      .data (xfer_data_i),
      .lp   (lp_all[g]),
      .colx (colx_all[g])
    );
  end

  nand_ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) rdo_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .rd       (rd_i),
    .lp_all   (lp_all),
    .colx_all (colx_all),
    .ptr      (rd_ptr),
    .ecc_o    (ecc_o)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int NUM_CHUNKS = 2,
  localparam int TOTAL   = NUM_CHUNKS << 8,
  localparam int CNT_W   = $clog2(TOTAL + 1),
  localparam int NUM_OUT = 3 * NUM_CHUNKS,
  localparam int PTR_W   = $clog2(NUM_OUT)
)(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             xfer_i,
  input logic             rd_i,
  input logic [7:0]       ecc_o,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [PTR_W-1:0] rd_ptr
);
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CNT_W'(TOTAL));

  a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01 && xfer_i && byte_cnt < CNT_W'(TOTAL))
      |=> (byte_cnt == $past(byte_cnt) + 1'b1));

  a_r2_clear_cnt: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11) |=> (byte_cnt == '0));

  a_r11_hold_cnt: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 || mode_i == 2'b10) |=> $stable(byte_cnt));

  a_r9_ptr_range: assert property (@(posedge clk) disable iff (rst)
    rd_ptr < PTR_W'(NUM_OUT));

  a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && rd_i && rd_ptr == PTR_W'(NUM_OUT-1)) |=> (rd_ptr == '0));

  a_r10_ptr_home: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b10) |=> (rd_ptr == '0));

  a_r12_out_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b10) |=> (ecc_o == 8'h00));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.NUM_CHUNKS(NUM_CHUNKS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .xfer_i   (xfer_i),
  .rd_i     (rd_i),
  .ecc_o    (ecc_o),
  .byte_cnt (byte_cnt),
  .rd_ptr   (rd_ptr)
);

// File: tb/nand_ecc_gen_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       xfer_i = 1'b0;
  logic [7:0] xfer_data_i = 8'h00;
  logic       rd_i = 1'b0;
  logic [7:0] ecc_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] m_data [512];
  int         m_cnt = 0;

  always #2 clk = ~clk;

  nand_ecc_gen dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .xfer_i(xfer_i),
    .xfer_data_i(xfer_data_i), .rd_i(rd_i), .ecc_o(ecc_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // expected code byte k (R3, R4, R5, R8)
  function automatic logic [7:0] exp_byte(input int k);
    int c = k / 3;
    int w = k % 3;
    logic [15:0] lp = '0;
    logic [7:0]  cx = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = m_data[c*256 + i];
      cx ^= d;
      if (^d)
        for (int a = 0; a < 8; a++) lp[2*a + ((i >> a) & 1)] ^= 1'b1;
    end
    for (int b = 0; b < 8; b++)
      if (cx[b])
        for (int j = 0; j < 3; j++) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
    case (w)
      0:       return ~lp[15:8];
      1:       return ~lp[7:0];
      default: return {~cp, 2'b11};
    endcase
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    if (m == 2'b11) begin
      for (int i = 0; i < 512; i++) m_data[i] = 8'h00;
      m_cnt = 0;
    end
  endtask

  task automatic start_session();
    set_mode(2'b11);
    set_mode(2'b00);
    set_mode(2'b01);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    xfer_i = 1'b1;
    xfer_data_i = d;
    if (mode_i == 2'b01 && m_cnt < 512) begin
      m_data[m_cnt] = d;
      m_cnt++;
    end
  endtask

  task automatic end_push();
    @(negedge clk);
    xfer_i = 1'b0;
  endtask

  task automatic drain_check(input string tag);
    set_mode(2'b10);
    @(negedge clk);
    check({tag, " R8 byte0"}, ecc_o, exp_byte(0));
    for (int k = 1; k < 6; k++) begin
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
      check($sformatf("%s R8 byte%0d", tag, k), ecc_o, exp_byte(k));
    end
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check({tag, " R9 wrap"}, ecc_o, exp_byte(0));
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check({tag, " R9 after wrap"}, ecc_o, exp_byte(1));
    set_mode(2'b00);
    @(negedge clk);
    check({tag, " R12 quiet off drain"}, ecc_o, 8'h00);
    set_mode(2'b10);
    @(negedge clk);
    check({tag, " R10 pointer home"}, ecc_o, exp_byte(0));
    set_mode(2'b00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0ecc));
    for (int i = 0; i < 512; i++) m_data[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", ecc_o, 8'h00);
    drain_check("R1 fresh");

    // random full sectors with differing density (R3 R4 R6)
    for (int s = 0; s < 3; s++) begin
      start_session();
      for (int i = 0; i < 512; i++) begin
        logic [7:0] d = 8'($urandom);
        if (s == 1 && ($urandom % 8) != 0) d = 8'h00;
        push(d);
      end
      end_push();
      set_mode(2'b00);
      drain_check($sformatf("R6 random s%0d", s));
      // R7: extra bytes after 512 are ignored
      set_mode(2'b01);
      for (int i = 0; i < 20; i++) push(8'($urandom) | 8'h01);
      end_push();
      set_mode(2'b00);
      drain_check("R7 overflow");
    end

    // R2: clear removes prior data; directed single bits in each chunk
    start_session();
    for (int i = 0; i < 300; i++)
      push(i == 37 ? 8'h04 : (i == 300 - 1 ? 8'h80 : 8'h00));
    end_push();
    set_mode(2'b00);
    drain_check("R2 R3 directed");

    // R5: erased chunk gives all 0xFF
    start_session();
    for (int i = 0; i < 256; i++) push(8'hFF);
    end_push();
    set_mode(2'b00);
    drain_check("R5 erased");
    check("R5 erased line", exp_byte(0), 8'hFF);

    // R11: transfers in off and drain modes are ignored
    start_session();
    for (int i = 0; i < 10; i++) push(8'($urandom));
    end_push();
    set_mode(2'b00);
    for (int i = 0; i < 5; i++) push(8'h5A);
    end_push();
    set_mode(2'b10);
    for (int i = 0; i < 5; i++) push(8'h3C);
    end_push();
    set_mode(2'b00);
    drain_check("R11 ignored xfer");
    set_mode(2'b01);
    push(8'h01);
    end_push();
    set_mode(2'b00);
    drain_check("R11 resume index");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule